// File: doc/BRIEF.md
# Single-Channel DMA Block Mover

This block moves a block of 32-bit words between a device data port and main memory while the processor does other work. Software loads a byte start address and a word count, then writes the control word with a start bit, a direction bit and a bus-use mode. The engine asks an external arbiter for the bus and gets it back through a request/grant pair. It then makes one memory access per word. After each memory beat it advances the address by one word and lowers the count by one.

When the last word has moved, the engine sets a done flag. If interrupts are enabled, it also latches an interrupt flag and drives the interrupt output. In cycle-stealing mode the bus is requested for each memory beat and released afterwards. In burst mode the request is raised once and held until the block ends. Memory and device ports use valid/ready handshakes. The processor can read the registers at any time through a combinational read port.

Top module: `dmaBlockMover`

## Requirements
- R1: The register offsets are fixed. Offset 0 is the byte start address, offset 1 is the word count and offset 2 is control. In the control word, bit 31 is the interrupt flag, bit 30 is the interrupt enable, bit 4 is busy (read-only), bit 3 is start (write-only, reads 0), bit 2 selects burst mode, bit 1 is done (read-only) and bit 0 is direction. All registers read 0 after reset, and the interrupt and bus request outputs are low.
- R2: A control write with bit 3 set, made while idle with a nonzero count, starts a transfer. From the next cycle done reads 0 and busy reads 1.
- R3: With direction 1, the words at consecutive memory addresses from the start address are delivered to the device port in address order.
- R4: With direction 0, the words taken from the device port are written to consecutive memory words in arrival order. The word just past the block is left unchanged.
- R5: Each accepted memory beat adds 4 to the address register and subtracts 1 from the count register. At the end, the address reads start + 4*count and the count reads 0.
- R6: A memory request is made only while the bus is requested and granted. Address and request hold steady until memory accepts.
- R7: In cycle-stealing mode (bit 2 = 0), the bus request drops after every memory beat, so it rises once per word. In burst mode (bit 2 = 1), it rises once and stays high until the block ends.
- R8: At block end, done reads 1. If the enable is set, the interrupt flag sets and the interrupt output goes high. If the enable is clear, both stay low.
- R9: Starting with a count of 0 sets done on the next cycle and leaves busy at 0. It makes no memory access and raises no bus request.
- R10: Writing 1 to bit 31 clears the interrupt flag. The interrupt output equals flag AND enable, so clearing the enable masks the output and leaves the flag set.
- R11: While busy, writes to the address, the count, direction, mode and start are ignored. The enable and the flag clear still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Register offset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| busReq | output | 1 | Bus request to arbiter |
| busGrant | input | 1 | Bus grant from arbiter |
| memValid | output | 1 | Memory access request |
| memReady | input | 1 | Memory accepts access |
| memWrite | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Memory byte address |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data, valid with memReady |
| devRxValid | input | 1 | Device offers a word |
| devRxReady | output | 1 | Engine takes device word |
| devRxData | input | DATA_W | Word from device |
| devTxValid | output | 1 | Engine offers a word to device |
| devTxReady | input | 1 | Device accepts word |
| devTxData | output | DATA_W | Word to device |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets several corner cases. A zero-count start must finish at once with no bus request; a design that missed this would request the bus and underflow the count, wrapping it. Register writes made in the middle of a transfer must not steer the address, the count or the direction; a design that let them through would scatter data or reverse the flow partway. The bench compares how often the bus request rises in each mode, so an engine that never releases the bus while cycle stealing, or that drops it during a burst, shows up as a count mismatch. Interrupt masking and write-one-to-clear are checked separately, which exposes a flag that clears on an enable write or an output that ignores the enable.

// File: rtl/dmaPkg.sv
package dmaPkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_DEVGET,
    ST_MEMACC,
    ST_DEVPUT
  } dmaState_e;

  typedef struct packed {
    logic finish;
    logic capture;
    logic step;
  } dmaStrobe_t;

  localparam logic [1:0] REG_ADDR  = 2'd0;
  localparam logic [1:0] REG_COUNT = 2'd1;
  localparam logic [1:0] REG_CTRL  = 2'd2;

  localparam int CB_IRQ   = 31;
  localparam int CB_IE    = 30;
  localparam int CB_BUSY  = 4;
  localparam int CB_START = 3;
  localparam int CB_BURST = 2;
  localparam int CB_DONE  = 1;
  localparam int CB_DIR   = 0;
endpackage

// File: rtl/dmaDatapath.sv
module dmaDatapath
  import dmaPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              busy,
  input  dmaStrobe_t        strb,
  output logic              startPulse,
  output logic              startDir,
  output logic              startBurst,
  output logic              cntZero,
  output logic              cntOne,
  output logic              dirRead,
  output logic              burstMode,
  output logic [ADDR_W-1:0] curAddr,
  output logic [DATA_W-1:0] bufData,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] devRxData,
  output logic              irqOut
);
  localparam int unsigned WORD_BYTES = DATA_W / 8;

  logic [ADDR_W-1:0] addrReg;
  logic [CNT_W-1:0]  cntReg;
  logic [DATA_W-1:0] bufReg;
  logic ieReg, irqReg, doneReg, dirReg, burstReg;
  logic ctrlWr, addrWr, cntWr, ieEff;

  assign ctrlWr     = regWrEn && (regAddr == REG_CTRL);
  assign addrWr     = regWrEn && (regAddr == REG_ADDR) && !busy;
  assign cntWr      = regWrEn && (regAddr == REG_COUNT) && !busy;
  assign startPulse = ctrlWr && regWrData[CB_START] && !busy;
  assign startDir   = regWrData[CB_DIR];
  assign startBurst = regWrData[CB_BURST];
  assign ieEff      = ctrlWr ? regWrData[CB_IE] : ieReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      cntReg   <= '0;
      bufReg   <= '0;
      ieReg    <= 1'b0;
      irqReg   <= 1'b0;
      doneReg  <= 1'b0;
      dirReg   <= 1'b0;
      burstReg <= 1'b0;
    end else begin
      if (addrWr)         addrReg <= regWrData[ADDR_W-1:0];
      else if (strb.step) addrReg <= addrReg + ADDR_W'(WORD_BYTES);

      if (cntWr)          cntReg <= regWrData[CNT_W-1:0];
      else if (strb.step) cntReg <= cntReg - CNT_W'(1);

      if (ctrlWr) ieReg <= regWrData[CB_IE];
      if (ctrlWr && !busy) begin
        dirReg   <= regWrData[CB_DIR];
        burstReg <= regWrData[CB_BURST];
      end

      if (strb.finish)     doneReg <= 1'b1;
      else if (startPulse) doneReg <= 1'b0;

      if (strb.finish && ieEff)               irqReg <= 1'b1;
      else if (ctrlWr && regWrData[CB_IRQ])   irqReg <= 1'b0;

      if (strb.capture) bufReg <= dirReg ? memRdata : devRxData;
    end
  end

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      REG_ADDR:  regRdData = 32'(addrReg);
      REG_COUNT: regRdData = 32'(cntReg);
      REG_CTRL: begin
        regRdData[CB_IRQ]   = irqReg;
        regRdData[CB_IE]    = ieReg;
        regRdData[CB_BUSY]  = busy;
        regRdData[CB_BURST] = burstReg;
        regRdData[CB_DONE]  = doneReg;
        regRdData[CB_DIR]   = dirReg;
      end
      default: regRdData = '0;
    endcase
  end

  assign cntZero   = (cntReg == '0);
  assign cntOne    = (cntReg == CNT_W'(1));
  assign dirRead   = dirReg;
  assign burstMode = burstReg;
  assign curAddr   = addrReg;
  assign bufData   = bufReg;
  assign irqOut    = irqReg & ieReg;

  // R5: the control never steps an exhausted count
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |-> !cntZero);

  // R11: address and count frozen while busy except on a beat
  a_r11_addr_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.step) |=> $stable(addrReg));
  a_r11_count_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.step) |=> $stable(cntReg));

  // R2: a real start clears done
  a_r2_done_clears: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !cntZero) |=> !doneReg);

  // R9: zero-count start finishes at once
  a_r9_zero_finish: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && cntZero) |=> (doneReg && !busy));

  // R8: the flag only rises together with done
  a_r8_irq_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReg) |-> doneReg);
endmodule

// File: rtl/dmaControl.sv
module dmaControl
  import dmaPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       startDir,
  input  logic       startBurst,
  input  logic       cntZero,
  input  logic       cntOne,
  input  logic       dirRead,
  input  logic       burstMode,
  input  logic       busGrant,
  output logic       busReq,
  output logic       memValid,
  input  logic       memReady,
  output logic       memWrite,
  input  logic       devRxValid,
  output logic       devRxReady,
  output logic       devTxValid,
  input  logic       devTxReady,
  output logic       busy,
  output dmaStrobe_t strb
);
  dmaState_e state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt        = state;
    strb       = '0;
    memValid   = 1'b0;
    memWrite   = 1'b0;
    devRxReady = 1'b0;
    devTxValid = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startPulse) begin
          if (cntZero)                    strb.finish = 1'b1;
          else if (startBurst || startDir) nxt = ST_ARB;
          else                            nxt = ST_DEVGET;
        end
      end
      ST_ARB: begin
        if (busGrant) nxt = (burstMode && !dirRead) ? ST_DEVGET : ST_MEMACC;
      end
      ST_DEVGET: begin
        devRxReady = 1'b1;
        if (devRxValid) begin
          strb.capture = 1'b1;
          nxt = burstMode ? ST_MEMACC : ST_ARB;
        end
      end
      ST_MEMACC: begin
        memValid = 1'b1;
        memWrite = !dirRead;
        if (memReady) begin
          strb.step = 1'b1;
          if (dirRead) begin
            strb.capture = 1'b1;
            nxt = ST_DEVPUT;
          end else if (cntOne) begin
            strb.finish = 1'b1;
            nxt = ST_IDLE;
          end else begin
            nxt = ST_DEVGET;
          end
        end
      end
      ST_DEVPUT: begin
        devTxValid = 1'b1;
        if (devTxReady) begin
          if (cntZero) begin
            strb.finish = 1'b1;
            nxt = ST_IDLE;
          end else begin
            nxt = burstMode ? ST_MEMACC : ST_ARB;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign busy   = (state != ST_IDLE);
  assign busReq = busy && (burstMode || state == ST_ARB || state == ST_MEMACC);

  // R6: memory is touched only under a bus request
  a_r6_mem_under_req: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> busReq);

  // R7: cycle stealing gives the bus back after each beat
  a_r7_steal_release: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady && !burstMode) |=> !busReq);

  // R7: burst keeps the request until the block ends
  a_r7_burst_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && burstMode && !strb.finish) |=> busReq);
endmodule

// File: rtl/dmaBlockMover.sv
module dmaBlockMover
  import dmaPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              busReq,
  input  logic              busGrant,
  output logic              memValid,
  input  logic              memReady,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              devRxValid,
  output logic              devRxReady,
  input  logic [DATA_W-1:0] devRxData,
  output logic              devTxValid,
  input  logic              devTxReady,
  output logic [DATA_W-1:0] devTxData,
  output logic              irq
);
  dmaStrobe_t        strb;
  logic              busy, startPulse, startDir, startBurst;
  logic              cntZero, cntOne, dirRead, burstMode;
  logic [DATA_W-1:0] bufData;

  dmaDatapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .busy       (busy),
    .strb       (strb),
    .startPulse (startPulse),
    .startDir   (startDir),
    .startBurst (startBurst),
    .cntZero    (cntZero),
    .cntOne     (cntOne),
    .dirRead    (dirRead),
    .burstMode  (burstMode),
    .curAddr    (memAddr),
    .bufData    (bufData),
    .memRdata   (memRdata),
    .devRxData  (devRxData),
    .irqOut     (irq)
  );

  dmaControl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .startDir   (startDir),
    .startBurst (startBurst),
    .cntZero    (cntZero),
    .cntOne     (cntOne),
    .dirRead    (dirRead),
    .burstMode  (burstMode),
    .busGrant   (busGrant),
    .busReq     (busReq),
    .memValid   (memValid),
    .memReady   (memReady),
    .memWrite   (memWrite),
    .devRxValid (devRxValid),
    .devRxReady (devRxReady),
    .devTxValid (devTxValid),
    .devTxReady (devTxReady),
    .busy       (busy),
    .strb       (strb)
  );

  assign memWdata  = bufData;
  assign devTxData = bufData;

  // R6: a pending memory request keeps its address until accepted
  a_r6_hold_addr: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr)));
endmodule

// File: tb/dmaBlockMover_tb.sv
module dmaBlockMover_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        busReq, memValid, memWrite, devRxReady, devTxValid, irq;
  logic        busGrant = 1'b0;
  logic [31:0] memAddr, memWdata, memRdata, devTxData, devRxData;
  logic        memReady, devRxValid, devTxReady;

  logic        stallOn = 1'b0, stallPhase = 1'b0, prevReq = 1'b0;
  logic        memInit = 1'b0, monClr = 1'b0, finished = 1'b0;
  logic [31:0] srcIdx = '0;
  int          reqRises = 0, memBeats = 0, ungranted = 0, sinkCnt = 0;
  logic [31:0] mem  [64];
  logic [31:0] sink [64];
  int          checks = 0, errors = 0;

  // entry: [15]dir [14]burst [13]stall [12]ie [11:6]start word [5:0]count
  localparam logic [15:0] VECS [6] = '{16'h9103, 16'hE285, 16'h3504,
                                      16'h5786, 16'hDA01, 16'h0C82};

  always #10 clk = ~clk;

  dmaBlockMover u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .busReq(busReq),
    .busGrant(busGrant), .memValid(memValid), .memReady(memReady),
    .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .devRxValid(devRxValid), .devRxReady(devRxReady),
    .devRxData(devRxData), .devTxValid(devTxValid), .devTxReady(devTxReady),
    .devTxData(devTxData), .irq(irq)
  );

  function automatic logic [31:0] initVal(int i);
    return 32'h5000_0000 + 32'(i) * 32'h0000_0101;
  endfunction

  assign memRdata   = mem[memAddr[7:2]];
  assign memReady   = memValid && (!stallOn || stallPhase);
  assign devTxReady = !stallOn || stallPhase;
  assign devRxValid = !stallOn || !stallPhase;
  assign devRxData  = 32'hA000_0000 | srcIdx;

  always @(posedge clk) begin
    busGrant   <= busReq;
    stallPhase <= ~stallPhase;
    prevReq    <= busReq;
    if (monClr) begin
      reqRises <= 0; memBeats <= 0; ungranted <= 0; sinkCnt <= 0;
    end else begin
      if (busReq && !prevReq) reqRises <= reqRises + 1;
      if (memValid && memReady) memBeats <= memBeats + 1;
      if (memValid && !busGrant) ungranted <= ungranted + 1;
      if (devTxValid && devTxReady) begin
        sink[sinkCnt[5:0]] <= devTxData;
        sinkCnt <= sinkCnt + 1;
      end
    end
    if (devRxValid && devRxReady) srcIdx <= srcIdx + 1;
    if (memInit) begin
      for (int i = 0; i < 64; i++) mem[i] <= initVal(i);
    end else if (memValid && memReady && memWrite) begin
      mem[memAddr[7:2]] <= memWdata;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1'b1;
    @(negedge clk); sig = 1'b0;
  endtask

  task automatic waitIdle();
    logic [31:0] c;
    for (int t = 0; t < 3000; t++) begin
      regRead(2'd2, c);
      if (!c[4]) return;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    regRead(2'd0, rd); check("R1 addr reset", rd, 32'h0);
    regRead(2'd1, rd); check("R1 count reset", rd, 32'h0);
    regRead(2'd2, rd); check("R1 ctrl reset", rd, 32'h0);
    check("R1 irq reset", {31'b0, irq}, 32'h0);
    check("R1 busReq reset", {31'b0, busReq}, 32'h0);

    // table walk
    for (int v = 0; v < 6; v++) begin
      logic        vDir, vBurst, vStall, vIe;
      int          vStart, vCnt;
      logic [31:0] srcBase;
      vDir   = VECS[v][15];
      vBurst = VECS[v][14];
      vStall = VECS[v][13];
      vIe    = VECS[v][12];
      vStart = int'(VECS[v][11:6]);
      vCnt   = int'(VECS[v][5:0]);
      stallOn = vStall;
      pulse(memInit);
      regWrite(2'd2, 32'h8000_0000 | (32'(vIe) << 30));
      regWrite(2'd0, 32'(vStart) * 4);
      regWrite(2'd1, 32'(vCnt));
      pulse(monClr);
      srcBase = srcIdx;
      regWrite(2'd2, (32'(vIe) << 30) | 32'h8 | (32'(vBurst) << 2) | 32'(vDir));
      // R2 and R1: busy set, done and start read 0
      regRead(2'd2, rd);
      check("R2 started", rd & 32'h1F, 32'h10 | (32'(vBurst) << 2) | 32'(vDir));
      waitIdle();
      for (int k = 0; k < vCnt; k++) begin
        if (vDir) check("R3 device word", sink[k], initVal(vStart + k));
        else      check("R4 memory word", mem[vStart + k], 32'hA000_0000 | (srcBase + 32'(k)));
      end
      check("R4 past block untouched", mem[vStart + vCnt], initVal(vStart + vCnt));
      regRead(2'd0, rd); check("R5 final addr", rd, 32'(vStart + vCnt) * 4);
      regRead(2'd1, rd); check("R5 final count", rd, 32'h0);
      check("R5 beat count", 32'(memBeats), 32'(vCnt));
      check("R6 ungranted access", 32'(ungranted), 32'h0);
      check("R7 request rises", 32'(reqRises), vBurst ? 32'h1 : 32'(vCnt));
      regRead(2'd2, rd);
      check("R8 done", {31'b0, rd[1]}, 32'h1);
      check("R8 irq flag", {31'b0, rd[31]}, {31'b0, vIe});
      check("R8 irq out", {31'b0, irq}, {31'b0, vIe});
    end
    stallOn = 1'b0;

    // R9: zero-count start
    regWrite(2'd2, 32'h8000_0000);
    regWrite(2'd1, 32'h0);
    pulse(monClr);
    regWrite(2'd2, 32'h4000_0008);
    regRead(2'd2, rd);
    check("R9 done at once", {31'b0, rd[1]}, 32'h1);
    check("R9 not busy", {31'b0, rd[4]}, 32'h0);
    check("R9 irq", {31'b0, irq}, 32'h1);
    repeat (4) @(negedge clk);
    check("R9 no access", 32'(memBeats), 32'h0);
    check("R9 no request", 32'(reqRises), 32'h0);

    // R10: masking and write-one-to-clear
    regWrite(2'd2, 32'h0000_0000);
    regRead(2'd2, rd);
    check("R10 masked out", {31'b0, irq}, 32'h0);
    check("R10 flag kept", {31'b0, rd[31]}, 32'h1);
    regWrite(2'd2, 32'h4000_0000);
    check("R10 unmasked", {31'b0, irq}, 32'h1);
    regWrite(2'd2, 32'hC000_0000);
    regRead(2'd2, rd);
    check("R10 cleared out", {31'b0, irq}, 32'h0);
    check("R10 cleared flag", {31'b0, rd[31]}, 32'h0);

    // R11: writes during a transfer
    stallOn = 1'b1;
    pulse(memInit);
    regWrite(2'd0, 32'd48);
    regWrite(2'd1, 32'd8);
    pulse(monClr);
    regWrite(2'd2, 32'h4000_0009);
    repeat (5) @(negedge clk);
    regWrite(2'd0, 32'h100);
    regWrite(2'd1, 32'd3);
    regWrite(2'd2, 32'h0000_000C);
    regRead(2'd0, rd);
    check("R11 addr write ignored", {31'b0, rd == 32'h100}, 32'h0);
    waitIdle();
    regRead(2'd0, rd); check("R11 final addr", rd, 32'd80);
    regRead(2'd1, rd); check("R11 final count", rd, 32'h0);
    for (int k = 0; k < 8; k++) check("R11 data kept direction", sink[k], initVal(12 + k));
    check("R11 mode kept", 32'(reqRises), 32'd8);
    regRead(2'd2, rd);
    check("R11 ie cleared while busy", {31'b0, rd[31]}, 32'h0);
    check("R11 irq low", {31'b0, irq}, 32'h0);
    check("R11 dir kept", {31'b0, rd[0]}, 32'h1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule